// File: doc/BRIEF.md
# Page-Relative Address Generator Sequencer

This block produces bus addresses and read/write strobes for the operand phase of a small 8-bit processor. When the decoder hands it an addressing class together with the program counter, the X and S registers and the direct-page select flag, it steps through that class one bus cycle per state. It returns the operand byte with a single-cycle ready pulse and, for stack classes, reports the new stack pointer.

Two windows of the 64 KiB space are reached by page-relative forms. The direct-page window is page 0 or page 1, selected by a status flag. The stack window is fixed to page 1. The indexed-indirect class fetches a 16-bit pointer from the direct page at (offset + X). It includes one idle bus cycle in which the index is added. All outputs come from registers, so the address and strobes for a state appear in the cycle that state is occupied.

Top module: `page_addr_seq`

## Requirements
- R1: After synchronous reset, bus_rd, bus_wr, operand_ready, s_update and pc_step are 0, bus_addr is 0 and seq_ready is 1.
- R2: Immediate class (mode 0): in the cycle after acceptance the block reads at pc_in with pc_step high for that one cycle. In the next cycle operand_ready rises with operand_data equal to the byte read.
- R3: A direct-page address has every upper bit zero except bit 8, which carries dp_sel, above the 8-bit offset. Direct class (mode 1) reads the offset at pc_in, then reads at that direct-page address, then signals ready with the byte read.
- R4: Indexed-indirect class (mode 2) takes six cycles in this order: read at pc_in with pc_step, an idle cycle, read pointer low at direct page (offset+X), read pointer high at direct page (offset+X+1), read data at {high,low}, then ready with that data byte.
- R5: Both offset+X and the +1 for the high pointer byte wrap within 8 bits, so both pointer reads stay inside the selected direct page.
- R6: The idle cycle of the indexed-indirect class drives neither bus_rd nor bus_wr.
- R7: Push (mode 3) writes push_data at address 0x0100 | S in the cycle after acceptance. In the next cycle it reports s_new = S - 1 (mod 256) with s_update high.
- R8: Pop (mode 4) reads at address 0x0100 | (S + 1 mod 256) in the cycle after acceptance. In the next cycle it reports s_new = S + 1 with s_update high and operand_data equal to the byte read.
- R9: operand_ready is high for exactly one cycle per operation, and seq_ready is high again in the following cycle.
- R10: start is ignored while seq_ready is low, and mode codes 5 to 7 are ignored; an ignored start causes no strobe and leaves seq_ready high when idle.
- R11: bus_rd and bus_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only when seq_ready is high |
| mode | input | 3 | Addressing class: 0 immediate, 1 direct, 2 indexed-indirect, 3 push, 4 pop |
| pc_in | input | 16 | Program counter of the operand byte |
| x_in | input | 8 | Index register X |
| s_in | input | 8 | Stack pointer S |
| dp_sel | input | 1 | Direct-page select flag (0: page 0, 1: page 1) |
| push_data | input | 8 | Byte to be written by a push |
| rdata | input | 8 | Read data returned for the current bus_addr |
| seq_ready | output | 1 | Sequencer idle and able to accept start |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| pc_step | output | 1 | PC increment request, high during the operand fetch cycle |
| operand_ready | output | 1 | One-cycle pulse when the operation completes |
| operand_data | output | 8 | Operand byte for read classes, valid with operand_ready |
| s_update | output | 1 | Pulse with a new stack pointer value |
| s_new | output | 8 | Updated stack pointer |

## Verification
The assertions assume that rdata is a combinational response to the registered bus_addr within the same cycle. They also assume that start, mode and the register inputs are stable across the clock edge that accepts an operation. The bench keeps to this by answering reads from an address-hashed memory function. It drives every input at the falling edge and samples outputs at the following falling edge. It holds start high through a whole operation only in the scenario that checks that a busy sequencer ignores it.

// File: rtl/page_addr_pkg.sv
package page_addr_pkg;

  typedef enum logic [2:0] {
    MD_IMM  = 3'd0,
    MD_DIR  = 3'd1,
    MD_IDX  = 3'd2,
    MD_PUSH = 3'd3,
    MD_POP  = 3'd4
  } pas_mode_e;

  typedef enum logic [3:0] {
    ST_READY = 4'd0,
    ST_OPF   = 4'd1,
    ST_IDLE  = 4'd2,
    ST_PLO   = 4'd3,
    ST_PHI   = 4'd4,
    ST_DRD   = 4'd5,
    ST_DPRD  = 4'd6,
    ST_PUSH  = 4'd7,
    ST_POP   = 4'd8,
    ST_DONE  = 4'd9
  } pas_state_e;

  function automatic logic mode_known(input logic [2:0] m);
    return m <= 3'd4;
  endfunction

endpackage

// File: rtl/pas_fsm.sv
module pas_fsm
  import page_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] mode,
  output logic       accept,
  output pas_state_e state_q,
  output pas_state_e state_nxt,
  output logic [2:0] mode_q
);

  assign accept = start && (state_q == ST_READY) && mode_known(mode);

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_READY: begin
        if (accept) begin
          if (mode == MD_PUSH)     state_nxt = ST_PUSH;
          else if (mode == MD_POP) state_nxt = ST_POP;
          else                     state_nxt = ST_OPF;
        end
      end
      ST_OPF: begin
        if (mode_q == MD_DIR)      state_nxt = ST_DPRD;
        else if (mode_q == MD_IDX) state_nxt = ST_IDLE;
        else                       state_nxt = ST_DONE;
      end
      ST_IDLE: state_nxt = ST_PLO;
      ST_PLO:  state_nxt = ST_PHI;
      ST_PHI:  state_nxt = ST_DRD;
      ST_DRD:  state_nxt = ST_DONE;
      ST_DPRD: state_nxt = ST_DONE;
      ST_PUSH: state_nxt = ST_DONE;
      ST_POP:  state_nxt = ST_DONE;
      ST_DONE: state_nxt = ST_READY;
      default: state_nxt = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_READY;
      mode_q  <= 3'd0;
    end else begin
      state_q <= state_nxt;
      if (accept) mode_q <= mode;
    end
  end

endmodule

// File: rtl/pas_regs.sv
module pas_regs
  import page_addr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  pas_state_e    state_q,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] s_in,
  input  logic          dp_sel,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] s_q,
  output logic          dp_q,
  output logic [DW-1:0] off_q,
  output logic [DW-1:0] idx_q,
  output logic [DW-1:0] lo_q,
  output logic [DW-1:0] idx_sum
);

  // index add is modulo 2^DW: pointer fetch never leaves the page
  assign idx_sum = off_q + x_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q   <= '0;
      s_q   <= '0;
      dp_q  <= 1'b0;
      off_q <= '0;
      idx_q <= '0;
      lo_q  <= '0;
    end else begin
      if (accept) begin
        x_q  <= x_in;
        s_q  <= s_in;
        dp_q <= dp_sel;
      end
      if (state_q == ST_OPF)  off_q <= rdata;
      if (state_q == ST_IDLE) idx_q <= idx_sum;
      if (state_q == ST_PLO)  lo_q  <= rdata;
    end
  end

endmodule

// File: rtl/pas_addr.sv
module pas_addr
  import page_addr_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            DW         = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 'h01
) (
  input  pas_state_e    state_nxt,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] s_in,
  input  logic          dp_q,
  input  logic [DW-1:0] idx_sum,
  input  logic [DW-1:0] idx_q,
  input  logic [DW-1:0] lo_q,
  input  logic [DW-1:0] rdata,
  input  logic [AW-1:0] cur_addr,
  output logic [AW-1:0] addr_nxt,
  output logic          rd_nxt,
  output logic          wr_nxt
);

  localparam int PW = AW - DW;
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] dp_page(input logic sel, input logic [DW-1:0] off);
    return {{(PW-1){1'b0}}, sel, off};
  endfunction

  always_comb begin
    addr_nxt = cur_addr;
    rd_nxt   = 1'b0;
    wr_nxt   = 1'b0;
    unique case (state_nxt)
      ST_OPF:  begin addr_nxt = pc_in;                       rd_nxt = 1'b1; end
      ST_PLO:  begin addr_nxt = dp_page(dp_q, idx_sum);      rd_nxt = 1'b1; end
      ST_PHI:  begin addr_nxt = dp_page(dp_q, idx_q + ONE);  rd_nxt = 1'b1; end
      ST_DRD:  begin addr_nxt = {rdata, lo_q};               rd_nxt = 1'b1; end
      ST_DPRD: begin addr_nxt = dp_page(dp_q, rdata);        rd_nxt = 1'b1; end
      ST_PUSH: begin addr_nxt = {STACK_PAGE, s_in};          wr_nxt = 1'b1; end
      ST_POP:  begin addr_nxt = {STACK_PAGE, s_in + ONE};    rd_nxt = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/page_addr_seq.sv
module page_addr_seq
  import page_addr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 'h01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] s_in,
  input  logic          dp_sel,
  input  logic [DW-1:0] push_data,
  input  logic [DW-1:0] rdata,
  output logic          seq_ready,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  output logic          pc_step,
  output logic          operand_ready,
  output logic [DW-1:0] operand_data,
  output logic          s_update,
  output logic [DW-1:0] s_new
);

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic          accept;
  pas_state_e    state_q, state_nxt;
  logic [2:0]    mode_q;
  logic [DW-1:0] x_q, s_q, off_q, idx_q, lo_q, idx_sum;
  logic          dp_q;
  logic [AW-1:0] addr_nxt;
  logic          rd_nxt, wr_nxt;

  pas_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .accept(accept), .state_q(state_q), .state_nxt(state_nxt), .mode_q(mode_q)
  );

  pas_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .accept(accept), .state_q(state_q),
    .x_in(x_in), .s_in(s_in), .dp_sel(dp_sel), .rdata(rdata),
    .x_q(x_q), .s_q(s_q), .dp_q(dp_q), .off_q(off_q), .idx_q(idx_q),
    .lo_q(lo_q), .idx_sum(idx_sum)
  );

  pas_addr #(.AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE)) u_addr (
    .state_nxt(state_nxt), .pc_in(pc_in), .s_in(s_in), .dp_q(dp_q),
    .idx_sum(idx_sum), .idx_q(idx_q), .lo_q(lo_q), .rdata(rdata),
    .cur_addr(bus_addr), .addr_nxt(addr_nxt), .rd_nxt(rd_nxt), .wr_nxt(wr_nxt)
  );

  assign seq_ready = (state_q == ST_READY);

  logic finishing;
  assign finishing = (state_nxt == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr      <= '0;
      bus_rd        <= 1'b0;
      bus_wr        <= 1'b0;
      bus_wdata     <= '0;
      pc_step       <= 1'b0;
      operand_ready <= 1'b0;
      operand_data  <= '0;
      s_update      <= 1'b0;
      s_new         <= '0;
    end else begin
      bus_addr      <= addr_nxt;
      bus_rd        <= rd_nxt;
      bus_wr        <= wr_nxt;
      pc_step       <= (state_nxt == ST_OPF);
      operand_ready <= finishing;
      s_update      <= finishing && (state_q == ST_PUSH || state_q == ST_POP);
      if (state_nxt == ST_PUSH) bus_wdata <= push_data;
      if (finishing && state_q != ST_PUSH) operand_data <= rdata;
      if (finishing && state_q == ST_PUSH) s_new <= s_q - ONE;
      if (finishing && state_q == ST_POP)  s_new <= s_q + ONE;
    end
  end

  // x_q and off_q feed idx_sum inside u_regs; mode_q steers the FSM
  logic unused_ok;
  assign unused_ok = ^{x_q, off_q, mode_q};

endmodule

// File: rtl/page_addr_seq_chk.sv
module page_addr_seq_chk
  import page_addr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 'h01
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [2:0]    mode,
  input logic [AW-1:0] pc_in,
  input pas_state_e    state_q,
  input logic          seq_ready,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          pc_step,
  input logic          operand_ready
);

  // R2 / R3 / R4: fetching classes read at the PC right after acceptance
  a_r2_fetch_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && seq_ready && (mode == MD_IMM || mode == MD_DIR || mode == MD_IDX))
      |=> (bus_rd && pc_step && bus_addr == $past(pc_in)));

  // R5: high pointer byte sits next to the low one, inside the same page
  a_r5_ptr_hi_adjacent: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PLO) |=> (bus_addr[DW-1:0] == DW'($past(bus_addr[DW-1:0]) + 1'b1)
                             && bus_addr[AW-1:DW] == $past(bus_addr[AW-1:DW])));

  // R6: idle cycle is quiet on the bus
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (!bus_rd && !bus_wr));

  // R7: every write targets the stack page
  a_r7_write_page_one: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> (bus_addr[AW-1:DW] == STACK_PAGE));

  // R9: ready pulse lasts one cycle, then the sequencer is idle
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    operand_ready |=> (!operand_ready && seq_ready));

  // R11: read and write strobes are exclusive
  a_r11_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

endmodule

bind page_addr_seq page_addr_seq_chk #(.AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE)) chk_i (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .pc_in(pc_in),
  .state_q(state_q), .seq_ready(seq_ready), .bus_addr(bus_addr),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .pc_step(pc_step),
  .operand_ready(operand_ready)
);

// File: tb/page_addr_seq_tb.sv
module page_addr_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] pc_in = '0;
  logic [7:0]  x_in = '0, s_in = '0, push_data = '0;
  logic        dp_sel = 1'b0;
  logic [7:0]  rdata;
  logic        seq_ready, bus_rd, bus_wr, pc_step, operand_ready, s_update;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, operand_data, s_new;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return ((a[7:0] * 8'd7) ^ a[15:8]) + 8'h3C;
  endfunction

  assign rdata = mbyte(bus_addr);

  page_addr_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .pc_in(pc_in),
    .x_in(x_in), .s_in(s_in), .dp_sel(dp_sel), .push_data(push_data),
    .rdata(rdata), .seq_ready(seq_ready), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .pc_step(pc_step), .operand_ready(operand_ready),
    .operand_data(operand_data), .s_update(s_update), .s_new(s_new)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [15:0] ra [0:11];
  logic        rrd [0:11];
  logic        rwr [0:11];
  logic        rstep [0:11];
  logic [7:0]  rwd [0:11];
  int          rlen;
  logic [7:0]  rdat, rsn;
  logic        rsu;

  // issue an operation and record every bus cycle until the ready pulse
  task automatic run_op(input logic [2:0] m, input logic [15:0] pc, input logic [7:0] x,
                        input logic [7:0] s, input logic dp, input logic [7:0] wd,
                        input bit hold);
    @(negedge clk);
    mode = m; pc_in = pc; x_in = x; s_in = s; dp_sel = dp; push_data = wd;
    start = 1'b1;
    rlen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (hold) begin
        mode = 3'd3; pc_in = 16'hFFFF; s_in = 8'h00;
      end else begin
        start = 1'b0;
      end
      ra[i] = bus_addr; rrd[i] = bus_rd; rwr[i] = bus_wr;
      rstep[i] = pc_step; rwd[i] = bus_wdata;
      if (operand_ready) begin
        rlen = i + 1; rdat = operand_data; rsu = s_update; rsn = s_new;
        start = 1'b0;
        break;
      end
    end
    @(negedge clk);
    chk(seq_ready && !operand_ready, "R9 ready back", {seq_ready, operand_ready}, 2'b10);
  endtask

  task automatic t_reset;
    chk(!bus_rd && !bus_wr && !operand_ready && !s_update && !pc_step,
        "R1 strobes", {bus_rd, bus_wr, operand_ready, s_update, pc_step}, 0);
    chk(bus_addr == 16'h0 && seq_ready, "R1 addr/ready", {bus_addr, seq_ready}, 1);
  endtask

  task automatic t_imm(input logic [15:0] pc);
    run_op(3'd0, pc, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    chk(rlen == 2, "R2 length", rlen, 2);
    chk(ra[0] == pc && rrd[0] && rstep[0] && !rstep[1], "R2 fetch", ra[0], pc);
    chk(rdat == mbyte(pc), "R2 data", rdat, mbyte(pc));
  endtask

  task automatic t_dir(input logic [15:0] pc, input logic dp);
    logic [15:0] ea;
    ea = {7'b0, dp, mbyte(pc)};
    run_op(3'd1, pc, 8'h00, 8'h00, dp, 8'h00, 1'b0);
    chk(rlen == 3 && ra[0] == pc && rrd[0], "R3 fetch", ra[0], pc);
    chk(ra[1] == ea && rrd[1], "R3 direct address", ra[1], ea);
    chk(rdat == mbyte(ea), "R3 data", rdat, mbyte(ea));
  endtask

  task automatic t_idx(input logic [15:0] pc, input logic [7:0] x, input logic dp,
                       input bit hold, input string tag);
    logic [7:0]  idx, lo, hi;
    logic [15:0] a_lo, a_hi, a_d;
    idx  = mbyte(pc) + x;
    a_lo = {7'b0, dp, idx};
    a_hi = {7'b0, dp, 8'(idx + 8'd1)};
    lo   = mbyte(a_lo);
    hi   = mbyte(a_hi);
    a_d  = {hi, lo};
    run_op(3'd2, pc, x, 8'h00, dp, 8'h00, hold);
    chk(rlen == 6, {tag, " R4 length"}, rlen, 6);
    chk(ra[0] == pc && rrd[0] && rstep[0], {tag, " R4 opfetch"}, ra[0], pc);
    chk(!rrd[1] && !rwr[1], {tag, " R6 idle quiet"}, {rrd[1], rwr[1]}, 0);
    chk(ra[2] == a_lo && rrd[2], {tag, " R5 ptr low"}, ra[2], a_lo);
    chk(ra[3] == a_hi && rrd[3], {tag, " R5 ptr high"}, ra[3], a_hi);
    chk(ra[4] == a_d && rrd[4], {tag, " R4 data addr"}, ra[4], a_d);
    chk(rdat == mbyte(a_d), {tag, " R4 data"}, rdat, mbyte(a_d));
    chk(!rwr[0] && !rwr[2] && !rwr[3] && !rwr[4], {tag, " R11 no write"}, 0, 0);
  endtask

  task automatic t_push(input logic [7:0] s, input logic [7:0] wd);
    run_op(3'd3, 16'h1234, 8'h00, s, 1'b0, wd, 1'b0);
    chk(rlen == 2 && rwr[0] && !rrd[0], "R7/R11 write strobe", {rwr[0], rrd[0]}, 2'b10);
    chk(ra[0] == {8'h01, s}, "R7 push address", ra[0], {8'h01, s});
    chk(rwd[0] == wd, "R7 push data", rwd[0], wd);
    chk(rsu && rsn == 8'(s - 8'd1), "R7 new S", rsn, 8'(s - 8'd1));
  endtask

  task automatic t_pop(input logic [7:0] s);
    logic [15:0] ea;
    ea = {8'h01, 8'(s + 8'd1)};
    run_op(3'd4, 16'h1234, 8'h00, s, 1'b1, 8'h00, 1'b0);
    chk(rlen == 2 && rrd[0] && ra[0] == ea, "R8 pop address", ra[0], ea);
    chk(rsu && rsn == 8'(s + 8'd1), "R8 new S", rsn, 8'(s + 8'd1));
    chk(rdat == mbyte(ea), "R8 pop data", rdat, mbyte(ea));
  endtask

  task automatic t_bad_mode;
    bit quiet;
    quiet = 1'b1;
    @(negedge clk);
    mode = 3'd6; pc_in = 16'h4444; start = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (bus_rd || bus_wr || !seq_ready || operand_ready) quiet = 1'b0;
    end
    start = 1'b0;
    chk(quiet, "R10 unknown mode ignored", quiet, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_imm(16'hC012);
    t_imm(16'h00FF);
    t_dir(16'h2222, 1'b0);
    t_dir(16'h2223, 1'b1);
    t_idx(16'h8001, 8'h05, 1'b0, 1'b0, "plain p0");
    t_idx(16'h8001, 8'h05, 1'b1, 1'b0, "plain p1");
    t_idx(16'h0450, 8'(8'hFF - mbyte(16'h0450)), 1'b1, 1'b0, "wrap ff");
    t_idx(16'h0451, 8'hF0, 1'b0, 1'b0, "wrap sum");
    t_idx(16'h3030, 8'h11, 1'b1, 1'b1, "R10 busy start");
    t_push(8'h7F, 8'hA5);
    t_push(8'h00, 8'h3C);
    t_pop(8'h40);
    t_pop(8'hFF);
    t_bad_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule